// File: doc/BRIEF.md
# Armed High/Low Phase Timer

This block takes one measurement of a square wave each time it is armed. It counts, in system clock cycles, the length of one high phase and then the low phase that follows it. A one-cycle arm pulse clears the previous result. The block then waits for a fresh rising edge of the measured signal. It enables a high-phase counter until the falling edge and then a low-phase counter until the next rising edge. At that point it raises a ready flag and stops.

The measured signal is asynchronous to the system clock. It passes through a synchroniser, and edges are taken from the synchronised copy. The same fixed delay applies to every edge, so it cancels out of both counts. The counts saturate at all ones, and an overflow flag shows that a phase was too long for the counter width. A consumer pulses arm, waits for ready, and then reads both counts. The counts hold their values until the next arm pulse.

Top module: `phase_timer`

## Requirements
- R1: After reset both enables, ready, overflow and both counts are 0. Without an arm pulse, activity on the measured signal changes none of them.
- R2: After an arm pulse nothing is counted until a rising edge of the measured signal. If the signal is already high when arm is seen, that high phase is skipped and counting starts at the following rising edge.
- R3: The high enable is asserted from the rising edge until the falling edge. The high count equals the number of clock edges at which the measured signal was sampled high.
- R4: The high enable falls and the low enable rises at the same clock edge. That edge is the third clock edge after the falling edge of the measured signal; the rising edge of the signal is followed in the same way.
- R5: The low enable stays asserted until the next rising edge. At that edge it drops and ready becomes 1. The low count equals the number of edges at which the signal was sampled low.
- R6: While ready is 1, both enables stay 0, further edges of the measured signal are ignored, and both counts stay unchanged.
- R7: An arm pulse seen in any state, including in the middle of a measurement, clears both counts, ready and overflow by the next clock edge. It then restarts the sequence at waiting for a rising edge.
- R8: Each count saturates at 2^CNT_W-1 and never wraps. The overflow output is 1 while either count is saturated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm_i | input | 1 | One-cycle pulse that clears the result and arms a measurement |
| sig_i | input | 1 | Asynchronous square wave being measured |
| hi_en_o | output | 1 | High-phase counter enable |
| lo_en_o | output | 1 | Low-phase counter enable |
| hi_count_o | output | CNT_W | High-phase length in clock cycles |
| lo_count_o | output | CNT_W | Low-phase length in clock cycles |
| ready_o | output | 1 | Measurement complete, counts valid |
| ovf_o | output | 1 | A count has saturated |

## Verification
The case that is hardest to reach from the ports is arming while the measured signal is already high. The partial high phase must be skipped, and this depends on the synchroniser delay and on arm taking priority over an edge in flight. The bench holds the signal high across the arm pulse and for several cycles after it, then drops it and raises it again. It checks that the count matches only the later, complete high phase. Saturation uses a narrower counter override so that a phase can run past all ones in a short run. A re-arm is also issued in the middle of a high phase.

// File: rtl/phase_timer_pkg.sv
`timescale 1ns/1ps
// Package: shared state type for the phase timer.
// Assumes: nothing beyond standard SystemVerilog.
package phase_timer_pkg;

    // Sequencer states; the order is the order of a measurement.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_HIGH  = 3'd2,
        ST_LOW   = 3'd3,
        ST_DONE  = 3'd4
    } seq_state_t;

endpackage

// File: rtl/pt_sync_edge.sv
`timescale 1ns/1ps
// Module: pt_sync_edge
// Brings an asynchronous level into the clock domain through a chain of
// STAGES flops. Edges are found by comparing the last stage with a copy
// delayed by one more cycle. Rise and fall are single-cycle pulses.
// Assumes: STAGES >= 2; the input is stable for at least two clock periods
// per level so that no edge is lost.
module pt_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o,
    output logic fall_o
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Synchroniser chain: first stage takes the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= async_i;
    end

    // Remaining synchroniser stages, one per generate step.
    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    endgenerate

    // Previous synchronised value for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    // Edge decode from the two registered values.
    always_comb begin
        rise_o = chain_q[STAGES-1] & ~prev_q;
        fall_o = ~chain_q[STAGES-1] & prev_q;
    end

endmodule

// File: rtl/pt_sequencer.sv
`timescale 1ns/1ps
// Module: pt_sequencer
// Single-shot measurement sequencer. Arm restarts from waiting-for-rise in
// any state. A rise starts the high phase, a fall moves to the low phase,
// and the next rise finishes. The block then halts until armed again.
// Assumes: rise_i and fall_i are never both high in one cycle.
module pt_sequencer
    import phase_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic rise_i,
    input  logic fall_i,
    output logic hi_en_o,
    output logic lo_en_o,
    output logic done_o
);

    seq_state_t state_q, state_d;

    // Next-state logic; arm has priority over every edge.
    always_comb begin
        state_d = state_q;
        if (arm_i) begin
            state_d = ST_ARMED;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_ARMED: if (rise_i) state_d = ST_HIGH;
                ST_HIGH:  if (fall_i) state_d = ST_LOW;
                ST_LOW:   if (rise_i) state_d = ST_DONE;
                ST_DONE:  state_d = ST_DONE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output decode straight from the state register (glitch free).
    always_comb begin
        hi_en_o = (state_q == ST_HIGH);
        lo_en_o = (state_q == ST_LOW);
        done_o  = (state_q == ST_DONE);
    end

endmodule

// File: rtl/pt_sat_counter.sv
`timescale 1ns/1ps
// Module: pt_sat_counter
// Up counter with synchronous clear that sticks at all ones.
// Assumes: clear has priority over increment.
module pt_sat_counter #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [WIDTH-1:0] count_o,
    output logic             full_o
);

    localparam logic [WIDTH-1:0] MAX_VAL = {WIDTH{1'b1}};

    logic [WIDTH-1:0] count_q;

    // Count register: clear, else increment below the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n)                            count_q <= '0;
        else if (clr_i)                        count_q <= '0;
        else if (inc_i && (count_q != MAX_VAL)) count_q <= count_q + 1'b1;
    end

    // Outputs.
    always_comb begin
        count_o = count_q;
        full_o  = (count_q == MAX_VAL);
    end

endmodule

// File: rtl/phase_timer.sv
`timescale 1ns/1ps
// Module: phase_timer (top)
// Armed single-shot timer for one high phase followed by one low phase of
// an asynchronous square wave, counted in clock cycles.
// Assumes: arm_i is synchronous to clk; sig_i levels last at least two
// clock periods.
module phase_timer #(
    parameter int CNT_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic             sig_i,
    output logic             hi_en_o,
    output logic             lo_en_o,
    output logic [CNT_W-1:0] hi_count_o,
    output logic [CNT_W-1:0] lo_count_o,
    output logic             ready_o,
    output logic             ovf_o
);

    logic rise_w, fall_w;
    logic hi_en_w, lo_en_w, done_w;
    logic hi_full_w, lo_full_w;

    pt_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (sig_i),
        .rise_o  (rise_w),
        .fall_o  (fall_w)
    );

    pt_sequencer seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_i   (arm_i),
        .rise_i  (rise_w),
        .fall_i  (fall_w),
        .hi_en_o (hi_en_w),
        .lo_en_o (lo_en_w),
        .done_o  (done_w)
    );

    pt_sat_counter #(.WIDTH(CNT_W)) hi_cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (arm_i),
        .inc_i   (hi_en_w),
        .count_o (hi_count_o),
        .full_o  (hi_full_w)
    );

    pt_sat_counter #(.WIDTH(CNT_W)) lo_cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (arm_i),
        .inc_i   (lo_en_w),
        .count_o (lo_count_o),
        .full_o  (lo_full_w)
    );

    // Output assembly.
    always_comb begin
        hi_en_o = hi_en_w;
        lo_en_o = lo_en_w;
        ready_o = done_w;
        ovf_o   = hi_full_w | lo_full_w;
    end

endmodule

// File: rtl/phase_timer_chk.sv
`timescale 1ns/1ps
// Module: phase_timer_chk
// Port-level properties of phase_timer, attached by bind below.
// Assumes: synchronous active-low reset.
module phase_timer_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arm_i,
    input logic             hi_en_o,
    input logic             lo_en_o,
    input logic [CNT_W-1:0] hi_count_o,
    input logic [CNT_W-1:0] lo_count_o,
    input logic             ready_o,
    input logic             ovf_o
);

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    // R3/R5: the two phases never overlap.
    assert_one_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_en_o && lo_en_o));

    // R6: ready implies both enables idle.
    assert_quiet_when_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (!hi_en_o && !lo_en_o));

    // R6: result held while ready and no arm.
    assert_result_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !arm_i) |=> (ready_o && $stable(hi_count_o) && $stable(lo_count_o)));

    // R7: arm clears the result by the next edge.
    assert_arm_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> (hi_count_o == '0 && lo_count_o == '0 && !ready_o && !ovf_o));

    // R4: high enable hands over directly to low enable.
    assert_handover_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_en_o && !arm_i) |=> (hi_en_o || lo_en_o));

    // R8: a saturated count stays saturated until arm.
    assert_hi_saturates_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_count_o == TOP && !arm_i) |=> (hi_count_o == TOP));
    assert_lo_saturates_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_count_o == TOP && !arm_i) |=> (lo_count_o == TOP));

endmodule

bind phase_timer phase_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_i      (arm_i),
    .hi_en_o    (hi_en_o),
    .lo_en_o    (lo_en_o),
    .hi_count_o (hi_count_o),
    .lo_count_o (lo_count_o),
    .ready_o    (ready_o),
    .ovf_o      (ovf_o)
);

// File: tb/phase_timer_tb_top.sv
`timescale 1ns/1ps
// Bench for phase_timer: vector table loop, then directed corner tests.
module phase_timer_tb_top;

    localparam int CNT_W = 8;
    localparam int NVEC  = 6;
    // Per row: cycles high before arm is released (0 = low at arm),
    // measured high cycles, measured low cycles.
    localparam int VEC [0:NVEC-1][0:2] = '{
        '{0,  5,  7},
        '{0,  2,  2},
        '{0, 17,  3},
        '{0,  4, 40},
        '{6,  9, 11},
        '{3,  3, 25}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             arm_i = 1'b0;
    logic             sig_i = 1'b0;
    logic             hi_en_o, lo_en_o, ready_o, ovf_o;
    logic [CNT_W-1:0] hi_count_o, lo_count_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    phase_timer #(.CNT_W(CNT_W), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .sig_i(sig_i),
        .hi_en_o(hi_en_o), .lo_en_o(lo_en_o),
        .hi_count_o(hi_count_o), .lo_count_o(lo_count_o),
        .ready_o(ready_o), .ovf_o(ovf_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_arm();
        arm_i = 1'b1;
        cyc(1);
        arm_i = 1'b0;
    endtask

    // Arm, optionally with the signal already high, then one high and one low.
    task automatic measure(input int pre, input int h, input int l);
        sig_i = (pre > 0);
        pulse_arm();
        if (pre > 0) begin
            cyc(pre);
            sig_i = 1'b0;
        end
        cyc(5);
        sig_i = 1'b1;
        cyc(h);
        sig_i = 1'b0;
        cyc(l);
        sig_i = 1'b1;
        cyc(4);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1: reset state
        chk("R1 hi_en", hi_en_o, 0);
        chk("R1 lo_en", lo_en_o, 0);
        chk("R1 ready", ready_o, 0);
        chk("R1 ovf", ovf_o, 0);
        chk("R1 hi_count", hi_count_o, 0);
        // R1: no arm, signal toggles are ignored
        for (int k = 0; k < 3; k++) begin
            sig_i = 1'b1; cyc(6);
            sig_i = 1'b0; cyc(6);
        end
        chk("R1 unarmed hi_count", hi_count_o, 0);
        chk("R1 unarmed lo_count", lo_count_o, 0);
        chk("R1 unarmed ready", ready_o, 0);

        // R2/R3/R5: vector table; rows with pre>0 exercise R2 skip
        for (int v = 0; v < NVEC; v++) begin
            measure(VEC[v][0], VEC[v][1], VEC[v][2]);
            chk("R5 ready", ready_o, 1);
            chk("R3 hi_count", hi_count_o, VEC[v][1]);
            chk("R5 lo_count", lo_count_o, VEC[v][2]);
            chk("R8 no ovf", ovf_o, 0);
            // R6: further edges ignored while ready
            sig_i = 1'b0; cyc(5);
            sig_i = 1'b1; cyc(5);
            chk("R6 hi held", hi_count_o, VEC[v][1]);
            chk("R6 lo held", lo_count_o, VEC[v][2]);
            chk("R6 hi_en idle", hi_en_o, 0);
            chk("R6 lo_en idle", lo_en_o, 0);
            chk("R6 ready held", ready_o, 1);
        end

        // R7: arm clears result
        sig_i = 1'b0;
        pulse_arm();
        chk("R7 clr hi", hi_count_o, 0);
        chk("R7 clr lo", lo_count_o, 0);
        chk("R7 clr ready", ready_o, 0);

        // R4 + R2: exact edge latency of enables (armed, signal low)
        cyc(4);
        chk("R2 armed no count", hi_en_o, 0);
        sig_i = 1'b1;
        cyc(2);
        chk("R4 hi_en before 3rd edge", hi_en_o, 0);
        cyc(1);
        chk("R4 hi_en at 3rd edge", hi_en_o, 1);
        cyc(5);
        sig_i = 1'b0;
        cyc(2);
        chk("R4 hi_en still high", hi_en_o, 1);
        chk("R4 lo_en still low", lo_en_o, 0);
        cyc(1);
        chk("R4 hi_en dropped", hi_en_o, 0);
        chk("R4 lo_en raised", lo_en_o, 1);
        cyc(6);
        sig_i = 1'b1;
        cyc(2);
        chk("R5 lo_en until rise", lo_en_o, 1);
        cyc(1);
        chk("R5 lo_en dropped", lo_en_o, 0);
        chk("R5 ready set", ready_o, 1);
        chk("R5 lo_count", lo_count_o, 9);
        chk("R3 hi_count", hi_count_o, 8);

        // R7: re-arm in the middle of a high phase
        sig_i = 1'b0; pulse_arm(); cyc(4);
        sig_i = 1'b1; cyc(10);
        chk("R7 mid hi_en", hi_en_o, 1);
        pulse_arm();
        chk("R7 mid clr hi", hi_count_o, 0);
        chk("R7 mid hi_en off", hi_en_o, 0);
        cyc(4);
        sig_i = 1'b0; cyc(6);
        sig_i = 1'b1; cyc(12);
        sig_i = 1'b0; cyc(5);
        sig_i = 1'b1; cyc(4);
        chk("R7 restart ready", ready_o, 1);
        chk("R7 restart hi", hi_count_o, 12);
        chk("R7 restart lo", lo_count_o, 5);

        // R8: saturation of the high count (CNT_W=8 -> 255)
        measure(0, 300, 10);
        chk("R8 hi sat", hi_count_o, 255);
        chk("R8 lo", lo_count_o, 10);
        chk("R8 ovf", ovf_o, 1);
        sig_i = 1'b0;
        pulse_arm();
        chk("R8 ovf cleared", ovf_o, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule